// File: doc/BRIEF.md
# Indirect-Register Memory Bank Mapper

This block sits between a game console's two address buses and a pair of large ROMs. It turns the top address bits of a CPU access and of a picture-processor access into the high address lines of a 128 kB program ROM and a 256 kB pattern ROM. Software programs the mapping through a two-step handshake. A write to the $8000-$9FFF range loads a 4-bit pointer. A later write to the $A000-$BFFF range stores the data byte into whichever of sixteen slots the pointer names.

Slots 0 to 7 choose 1 kB pattern banks for the eight 1 kB windows of the picture-processor space below $2000. Slots 8 to 11 choose 8 kB program banks for the CPU windows at $6000, $8000, $A000 and $C000. The window at $E000 always shows the last program bank. Slots 13, 14 and 15 belong to an interrupt counter that lives in a neighbouring block, so this block only decodes writes to them into one-cycle strobes and passes the data on. Slot 12 has no effect. Nametable mirroring is hard-wired to vertical.

All register updates happen on the rising edge of the CPU cycle clock. The address outputs are purely combinational from the current address and the stored slots.

Top module: `bankmap_top`

## Requirements
- R1: After reset the pointer and all twelve bank slots read as zero. Every pattern window and the four switchable program windows then give bank 0, and the $E000 window gives bank 15.
- R2: A write (cpu_en=1, cpu_wr=1) with CPU A15..A13 = 100 loads cpu_data[3:0] into the pointer. cpu_data[7:4] is ignored.
- R3: A write with A15..A13 = 101 stores cpu_data into the slot the pointer names. The new bank appears on the outputs only after the clock edge that ends the write cycle.
- R4: chr_bank equals slot n, where n is picture-processor A12..A10 (ppu_a_hi[2:0]). Slots 0 to 7 are 8 bits wide.
- R5: Slots 8, 9, 10 and 11 take cpu_data[3:0] only. They drive prg_bank for the CPU windows A15..A13 = 011, 100, 101 and 110 respectively.
- R6: With A15..A13 = 111, prg_bank is 15 (all ones), whatever the slots hold.
- R7: prg_cs is 1 exactly when cpu_en=1, cpu_wr=0 and the CPU address is $6000 or higher (A15..A13 not 000, 001 or 010).
- R8: chr_cs is 1 exactly when ppu_en=1 and picture-processor A13 (ppu_a_hi[3]) is 0.
- R9: nt_a10 always equals picture-processor A10 (ppu_a_hi[0]), which gives vertical mirroring.
- R10: A data write with pointer 13, 14 or 15 raises ctr_ctl_we, ctr_lo_we or ctr_hi_we respectively during that write cycle, with ctr_wdata equal to cpu_data. A data write with pointer 12 to 15 changes no bank slot.
- R11: Writes outside $8000-$BFFF, and reads anywhere, change neither the pointer nor any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_a_hi | input | 3 | CPU address bits 15..13 |
| cpu_data | input | 8 | CPU write data |
| cpu_en | input | 1 | CPU cycle active |
| cpu_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| ppu_a_hi | input | 4 | Picture-processor address bits 13..10 |
| ppu_en | input | 1 | Picture-processor access active |
| prg_bank | output | 4 | Program ROM address bits 16..13 |
| prg_cs | output | 1 | Program ROM select |
| chr_bank | output | 8 | Pattern ROM address bits 17..10 |
| chr_cs | output | 1 | Pattern ROM select |
| nt_a10 | output | 1 | Nametable RAM address bit 10 |
| ctr_wdata | output | 8 | Data toward the interrupt counter block |
| ctr_ctl_we | output | 1 | Counter control write strobe |
| ctr_lo_we | output | 1 | Counter low byte write strobe |
| ctr_hi_we | output | 1 | Counter high byte write strobe |

## Verification
A pattern fetch through window n can share a cycle with a CPU data write to slot n. The bench provokes this by holding the picture-processor address in that window while the write is on the bus. It expects the old bank before the clock edge and the written bank just after it. A counter-strobe write can likewise land in the same cycle as pattern and program lookups. The bench checks that the strobe fires while every window keeps its bank.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    localparam int PTR_W        = 4;
    localparam int CHR_WIN      = 8;
    localparam int PRG_WIN      = 4;
    localparam int CHR_SEL_W    = $clog2(CHR_WIN);
    localparam int PRG_REG_BASE = CHR_WIN;

    localparam logic [PTR_W-1:0] SEL_CTR_CTL = 4'd13;
    localparam logic [PTR_W-1:0] SEL_CTR_LO  = 4'd14;
    localparam logic [PTR_W-1:0] SEL_CTR_HI  = 4'd15;

    typedef enum logic [2:0] {
        RGN_LOW,
        RGN_W6,
        RGN_W8,
        RGN_WA,
        RGN_WC,
        RGN_WE
    } cpu_rgn_t;

    function automatic cpu_rgn_t region_of(input logic [2:0] a_hi);
        cpu_rgn_t r;
        unique case (a_hi)
            3'b011:  r = RGN_W6;
            3'b100:  r = RGN_W8;
            3'b101:  r = RGN_WA;
            3'b110:  r = RGN_WC;
            3'b111:  r = RGN_WE;
            default: r = RGN_LOW;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bankmap_cpu_decode.sv
module bankmap_cpu_decode
    import bankmap_pkg::*;
(
    input  logic [2:0] cpu_a_hi,
    input  logic       cpu_en,
    input  logic       cpu_wr,
    output cpu_rgn_t   rgn,
    output logic       ptr_we,
    output logic       data_we,
    output logic       rd_act
);

    always_comb begin
        rgn     = region_of(cpu_a_hi);
        ptr_we  = 1'b0;
        data_we = 1'b0;
        rd_act  = cpu_en & ~cpu_wr;
        if (cpu_en && cpu_wr) begin
            unique case (rgn)
                RGN_W8:  ptr_we  = 1'b1;
                RGN_WA:  data_we = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bankmap_regs.sv
module bankmap_regs
    import bankmap_pkg::*;
#(
    parameter int CHR_BANK_W = 8,
    parameter int PRG_BANK_W = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 ptr_we,
    input  logic                                 data_we,
    input  logic [7:0]                           wdata,
    output logic [PTR_W-1:0]                     ptr_q,
    output logic [CHR_WIN-1:0][CHR_BANK_W-1:0]   chr_q,
    output logic [PRG_WIN-1:0][PRG_BANK_W-1:0]   prg_q,
    output logic                                 ctr_ctl_we,
    output logic                                 ctr_lo_we,
    output logic                                 ctr_hi_we
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (ptr_we)
            ptr_q <= wdata[PTR_W-1:0];
    end

    for (genvar g = 0; g < CHR_WIN; g++) begin : g_chr
        localparam logic [PTR_W-1:0] SEL = PTR_W'(g);
        logic [CHR_BANK_W-1:0] slot;
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot <= '0;
            else if (data_we && ptr_q == SEL)
                slot <= wdata[CHR_BANK_W-1:0];
        end
        assign chr_q[g] = slot;
    end

    for (genvar g = 0; g < PRG_WIN; g++) begin : g_prg
        localparam logic [PTR_W-1:0] SEL = PTR_W'(PRG_REG_BASE + g);
        logic [PRG_BANK_W-1:0] slot;
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot <= '0;
            else if (data_we && ptr_q == SEL)
                slot <= wdata[PRG_BANK_W-1:0];
        end
        assign prg_q[g] = slot;
    end

    always_comb begin
        ctr_ctl_we = data_we && (ptr_q == SEL_CTR_CTL);
        ctr_lo_we  = data_we && (ptr_q == SEL_CTR_LO);
        ctr_hi_we  = data_we && (ptr_q == SEL_CTR_HI);
    end

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> ptr_q == $past(wdata[PTR_W-1:0])); // R2

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_we |=> $stable(ptr_q)); // R11

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !data_we |=> $stable(chr_q) && $stable(prg_q)); // R11

    AST_CTR_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && ptr_q >= 4'd12) |=> $stable(chr_q) && $stable(prg_q)); // R10

    AST_CTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctr_ctl_we, ctr_lo_we, ctr_hi_we})); // R10

endmodule

// File: rtl/bankmap_prg_map.sv
module bankmap_prg_map
    import bankmap_pkg::*;
#(
    parameter int PRG_BANK_W = 4
) (
    input  cpu_rgn_t                              rgn,
    input  logic [PRG_WIN-1:0][PRG_BANK_W-1:0]    prg_q,
    output logic [PRG_BANK_W-1:0]                 prg_bank
);

    always_comb begin
        prg_bank = '0;
        unique case (rgn)
            RGN_W6:  prg_bank = prg_q[0];
            RGN_W8:  prg_bank = prg_q[1];
            RGN_WA:  prg_bank = prg_q[2];
            RGN_WC:  prg_bank = prg_q[3];
            RGN_WE:  prg_bank = '1;
            default: prg_bank = '0;
        endcase
    end

endmodule

// File: rtl/bankmap_chr_map.sv
module bankmap_chr_map
    import bankmap_pkg::*;
#(
    parameter int CHR_BANK_W = 8
) (
    input  logic [CHR_SEL_W:0]                    ppu_a_hi,
    input  logic                                  ppu_en,
    input  logic [CHR_WIN-1:0][CHR_BANK_W-1:0]    chr_q,
    output logic [CHR_BANK_W-1:0]                 chr_bank,
    output logic                                  chr_cs,
    output logic                                  nt_a10
);

    always_comb begin
        chr_bank = chr_q[ppu_a_hi[CHR_SEL_W-1:0]];
        chr_cs   = ppu_en && !ppu_a_hi[CHR_SEL_W];
        nt_a10   = ppu_a_hi[0];
    end

endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
    import bankmap_pkg::*;
#(
    parameter int CHR_BANK_W = 8,
    parameter int PRG_BANK_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            cpu_a_hi,
    input  logic [7:0]            cpu_data,
    input  logic                  cpu_en,
    input  logic                  cpu_wr,
    input  logic [CHR_SEL_W:0]    ppu_a_hi,
    input  logic                  ppu_en,
    output logic [PRG_BANK_W-1:0] prg_bank,
    output logic                  prg_cs,
    output logic [CHR_BANK_W-1:0] chr_bank,
    output logic                  chr_cs,
    output logic                  nt_a10,
    output logic [7:0]            ctr_wdata,
    output logic                  ctr_ctl_we,
    output logic                  ctr_lo_we,
    output logic                  ctr_hi_we
);

    cpu_rgn_t                             rgn;
    logic                                 ptr_we;
    logic                                 data_we;
    logic                                 rd_act;
    logic [PTR_W-1:0]                     ptr_q;
    logic [CHR_WIN-1:0][CHR_BANK_W-1:0]   chr_q;
    logic [PRG_WIN-1:0][PRG_BANK_W-1:0]   prg_q;

    bankmap_cpu_decode u_dec (
        .cpu_a_hi (cpu_a_hi),
        .cpu_en   (cpu_en),
        .cpu_wr   (cpu_wr),
        .rgn      (rgn),
        .ptr_we   (ptr_we),
        .data_we  (data_we),
        .rd_act   (rd_act)
    );

    bankmap_regs #(
        .CHR_BANK_W (CHR_BANK_W),
        .PRG_BANK_W (PRG_BANK_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_we     (ptr_we),
        .data_we    (data_we),
        .wdata      (cpu_data),
        .ptr_q      (ptr_q),
        .chr_q      (chr_q),
        .prg_q      (prg_q),
        .ctr_ctl_we (ctr_ctl_we),
        .ctr_lo_we  (ctr_lo_we),
        .ctr_hi_we  (ctr_hi_we)
    );

    bankmap_prg_map #(
        .PRG_BANK_W (PRG_BANK_W)
    ) u_prg (
        .rgn      (rgn),
        .prg_q    (prg_q),
        .prg_bank (prg_bank)
    );

    bankmap_chr_map #(
        .CHR_BANK_W (CHR_BANK_W)
    ) u_chr (
        .ppu_a_hi (ppu_a_hi),
        .ppu_en   (ppu_en),
        .chr_q    (chr_q),
        .chr_bank (chr_bank),
        .chr_cs   (chr_cs),
        .nt_a10   (nt_a10)
    );

    assign prg_cs    = rd_act && (rgn != RGN_LOW);
    assign ctr_wdata = cpu_data;

    AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_a_hi == 3'b111) |-> (prg_bank == '1)); // R6

    AST_PRG_CS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        prg_cs |-> (cpu_en && !cpu_wr && cpu_a_hi >= 3'b011)); // R7

    AST_CHR_CS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        chr_cs |-> !ppu_a_hi[CHR_SEL_W]); // R8

    AST_LOW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && cpu_wr && !cpu_a_hi[2]) |=>
            $stable(chr_q) && $stable(prg_q) && $stable(ptr_q)); // R11

endmodule

// File: tb/bankmap_top_test.sv
module bankmap_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        cpu_en, cpu_wr;
    logic [3:0]  ppu_a_hi;
    logic        ppu_en;
    logic [3:0]  prg_bank;
    logic        prg_cs;
    logic [7:0]  chr_bank;
    logic        chr_cs, nt_a10;
    logic [7:0]  ctr_wdata;
    logic        ctr_ctl_we, ctr_lo_we, ctr_hi_we;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] exp_chr [8];
    logic [3:0] exp_prg [4];

    always #5 clk = ~clk;

    bankmap_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_a_hi   (cpu_addr[15:13]),
        .cpu_data   (cpu_data),
        .cpu_en     (cpu_en),
        .cpu_wr     (cpu_wr),
        .ppu_a_hi   (ppu_a_hi),
        .ppu_en     (ppu_en),
        .prg_bank   (prg_bank),
        .prg_cs     (prg_cs),
        .chr_bank   (chr_bank),
        .chr_cs     (chr_cs),
        .nt_a10     (nt_a10),
        .ctr_wdata  (ctr_wdata),
        .ctr_ctl_we (ctr_ctl_we),
        .ctr_lo_we  (ctr_lo_we),
        .ctr_hi_we  (ctr_hi_we)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_en = 1'b1; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_en = 1'b0; cpu_wr = 1'b0; cpu_addr = 16'h0000;
    endtask

    task automatic set_slot(input int n, input logic [7:0] d);
        cpu_write(16'h8000 + 16'(n * 16'h0111), {4'hA, 4'(n)});
        cpu_write(16'hA000 + 16'(n * 16'h0123), d);
    endtask

    task automatic probe_chr(input int w, input string req);
        @(negedge clk);
        ppu_a_hi = 4'(w); ppu_en = 1'b1;
        #1;
        chk(req, chr_bank, exp_chr[w]);
    endtask

    task automatic probe_prg(input logic [15:0] a, input int exp, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_en = 1'b1; cpu_wr = 1'b0;
        #1;
        chk(req, prg_bank, exp);
        cpu_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        for (int w = 0; w < 8; w++) probe_chr(w, req);
        for (int w = 0; w < 4; w++)
            probe_prg(16'h6000 + 16'(w * 16'h2000) + 16'h0ABC, exp_prg[w], req);
        probe_prg(16'hF123, 15, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cpu_addr = '0; cpu_data = '0; cpu_en = 0; cpu_wr = 0;
        ppu_a_hi = '0; ppu_en = 0;
        for (int i = 0; i < 8; i++) exp_chr[i] = '0;
        for (int i = 0; i < 4; i++) exp_prg[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        check_all("R1");

        // R3 R4 R2: load each pattern slot, verify all windows
        for (int n = 0; n < 8; n++) begin
            set_slot(n, 8'(n * 29 + 7));
            exp_chr[n] = 8'(n * 29 + 7);
            for (int w = 0; w < 8; w++) probe_chr(w, "R4");
        end

        // R4: exhaustive value sweep on slot 5, neighbour untouched
        for (int v = 0; v < 256; v++) begin
            set_slot(5, 8'(v));
            exp_chr[5] = 8'(v);
            probe_chr(5, "R4");
            probe_chr(4, "R3");
        end

        // R5: every nibble in every program slot, high nibble ignored
        for (int w = 0; w < 4; w++) begin
            for (int v = 0; v < 16; v++) begin
                set_slot(8 + w, {4'(~v), 4'(v)});
                exp_prg[w] = 4'(v);
                for (int k = 0; k < 4; k++)
                    probe_prg(16'h6000 + 16'(k * 16'h2000) + 16'(v * 16'h0101),
                              exp_prg[k], "R5");
            end
        end

        // R6: fixed top window across its range
        for (int a = 16'hE000; a <= 16'hFFFF; a += 16'h0301)
            probe_prg(16'(a), 15, "R6");

        // R7: program select sweep
        for (int r = 0; r < 8; r++)
            for (int en = 0; en < 2; en++)
                for (int wr = 0; wr < 2; wr++) begin
                    @(negedge clk);
                    cpu_addr = 16'(r << 13); cpu_en = en[0]; cpu_wr = wr[0];
                    #1;
                    chk("R7", prg_cs, int'(en == 1 && wr == 0 && r >= 3));
                    cpu_en = 1'b0; cpu_wr = 1'b0;
                end

        // R8 R9: pattern select and mirroring sweep
        for (int p = 0; p < 16; p++)
            for (int en = 0; en < 2; en++) begin
                @(negedge clk);
                ppu_a_hi = 4'(p); ppu_en = en[0];
                #1;
                chk("R8", chr_cs, int'(en == 1 && p < 8));
                chk("R9", nt_a10, p & 1);
            end

        // R10: counter slots raise strobes, leave banks alone
        for (int p = 12; p < 16; p++) begin
            cpu_write(16'h9FFF, 8'(p));
            @(negedge clk);
            ppu_a_hi = 4'd5; ppu_en = 1'b1;
            cpu_addr = 16'hB456; cpu_data = 8'(p * 11); cpu_en = 1'b1; cpu_wr = 1'b1;
            #1;
            chk("R10", ctr_ctl_we, int'(p == 13));
            chk("R10", ctr_lo_we,  int'(p == 14));
            chk("R10", ctr_hi_we,  int'(p == 15));
            chk("R10", ctr_wdata,  (p * 11) & 255);
            chk("R10", chr_bank,   exp_chr[5]);
            @(negedge clk);
            cpu_en = 1'b0; cpu_wr = 1'b0;
            check_all("R10");
        end

        // R11: writes outside the register ranges and reads change nothing
        cpu_write(16'h8000, 8'h02);
        cpu_write(16'h6000, 8'h0F);
        cpu_write(16'hC000, 8'h0E);
        cpu_write(16'hE000, 8'h0D);
        cpu_write(16'h4000, 8'h01);
        cpu_write(16'h7FFF, 8'hFF);
        probe_prg(16'hA000, exp_prg[2], "R11");
        check_all("R11");
        cpu_write(16'hA000, 8'h99);
        exp_chr[2] = 8'h99;
        probe_chr(2, "R11");

        // R3: fetch and slot write in the same cycle
        cpu_write(16'h8000, 8'h06);
        @(negedge clk);
        ppu_a_hi = 4'd6; ppu_en = 1'b1;
        cpu_addr = 16'hA000; cpu_data = 8'h3C; cpu_en = 1'b1; cpu_wr = 1'b1;
        #1;
        chk("R3", chr_bank, exp_chr[6]);
        @(posedge clk);
        #1;
        chk("R3", chr_bank, 8'h3C);
        @(negedge clk);
        cpu_en = 1'b0; cpu_wr = 1'b0;
        exp_chr[6] = 8'h3C;
        check_all("R3");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule